// File: doc/BRIEF.md
# SCSI Byte Staging Path with Occupancy Status

This block moves single bytes between the DMA side of a SCSI controller and the SCSI data side, in both directions. Bytes for transmission are accepted from the DMA side into an output latch. In asynchronous mode the latch drives the SCSI side directly. In synchronous mode the latch feeds a second, software-invisible holding register, and that register drives the SCSI side. Received bytes arriving in asynchronous mode are caught in an input latch before the DMA side takes them. In synchronous mode received bytes bypass that latch and reach the DMA side combinationally.

Each interface uses a valid/ready handshake. A read-only status byte reports which of the three staging registers currently hold a byte. After a transfer error, software adds up the set flags to learn how many bytes are still inside the block. It then uses the synchronous flush input to discard them. The transfer mode is sampled from an input. A new value is taken only while the path is completely idle.

Top module: `scsi_stage_path`

## Requirements
- R1: After reset the status byte is 0x00, both output valids are low, and the active mode is asynchronous (`sync_active_o` = 0).
- R2: In asynchronous mode (`sync_mode_i` = 0), a transmit byte accepted at a clock edge is presented on the SCSI transmit side after that one edge. Bytes leave in acceptance order, and status bit 6 stays 0.
- R3: In synchronous mode (`sync_mode_i` = 1), a transmit byte accepted at a clock edge is presented on the SCSI side only after the second edge. It spends one cycle in the output latch (status bit 5) and then sits in the holding register (status bit 6). Up to two bytes can be resident, and order is preserved.
- R4: In asynchronous mode, a received byte accepted at an edge sets status bit 7 and is presented on the DMA receive side after that one edge.
- R5: In synchronous mode, received bytes pass straight through in the same cycle. `dma_rx_valid_o` and `dma_rx_data_o` follow the SCSI input, `scsi_rx_ready_o` follows `dma_rx_ready_i`, and status bit 7 stays 0.
- R6: A stage flag sets on the edge where a byte enters the stage. It clears on the edge where the byte moves on, unless a new byte enters on that same edge. With both sides always ready, the path sustains one byte per cycle.
- R7: A stage accepts a byte only when it is empty or is emptying on the same edge. While a presented byte is not taken, it stays valid and unchanged.
- R8: A high `flush_i` at an edge empties all three stages. The status byte reads 0x00 and both output valids are low after that edge. No byte is accepted while `flush_i` is high.
- R9: A new `sync_mode_i` value takes effect only at an edge where all three stages are empty and neither `dma_tx_valid_i` nor `scsi_rx_valid_i` is high. At any other edge the value is ignored, and `sync_active_o` keeps the old mode.
- R10: Status bits 4 down to 0 always read 0.
- R11: The number of bytes held inside the block always equals the count of ones in status bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous discard of all staged bytes |
| sync_mode_i | input | 1 | Requested mode: 1 synchronous, 0 asynchronous |
| sync_active_o | output | 1 | Mode currently in force |
| dma_tx_valid_i | input | 1 | DMA side offers a transmit byte |
| dma_tx_data_i | input | DATA_W | Transmit byte from the DMA side |
| dma_tx_ready_o | output | 1 | Output latch takes the byte at this edge |
| scsi_tx_valid_o | output | 1 | Byte presented to the SCSI side |
| scsi_tx_data_o | output | DATA_W | Transmit byte to the SCSI side |
| scsi_tx_ready_i | input | 1 | SCSI side takes the byte |
| scsi_rx_valid_i | input | 1 | SCSI side offers a received byte |
| scsi_rx_data_i | input | DATA_W | Received byte from the SCSI side |
| scsi_rx_ready_o | output | 1 | Block takes the received byte |
| dma_rx_valid_o | output | 1 | Received byte presented to the DMA side |
| dma_rx_data_o | output | DATA_W | Received byte to the DMA side |
| dma_rx_ready_i | input | 1 | DMA side takes the received byte |
| status_o | output | 8 | Occupancy flags: bit 7 input latch, bit 6 holding register, bit 5 output latch |

## Verification
Several properties are checked on every cycle by the assertions. A stalled byte holds still. A flag sets on every accepted byte. The holding register stays idle in asynchronous mode, and the input latch stays idle in synchronous mode. A flush empties the status. The active mode changes only out of an empty path. Other properties can only be shown by the bench's scenarios: the exact one-edge and two-edge latencies, byte ordering across many valid and ready patterns, equality of the flag count with the bytes in flight, and the refusal of a mode change while bytes are resident.

// File: rtl/scsi_stage_pkg.sv
`timescale 1ns/1ps
package scsi_stage_pkg;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned BIT_RX_LATCH = 7;
  localparam int unsigned BIT_TX_HOLD  = 6;
  localparam int unsigned BIT_TX_LATCH = 5;
endpackage

// File: rtl/scsi_stage_reg.sv
`timescale 1ns/1ps
module scsi_stage_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              full_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign in_ready_o  = !flush_i && (!full_q || out_ready_i);
  assign take        = in_valid_i && in_ready_o;
  assign out_valid_o = full_q;
  assign out_data_o  = data_q;
  assign full_o      = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush_i) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end else if (out_ready_i) begin
      full_q <= 1'b0;
    end
  end

  p_keep_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !out_ready_i && !flush_i |=> full_q && $stable(data_q));

  p_fill_on_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> full_q);

  p_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && out_ready_i && !in_valid_i |=> !full_q);
endmodule

// File: rtl/scsi_tx_stage.sv
`timescale 1ns/1ps
module scsi_tx_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              sync_i,
  input  logic              dma_valid_i,
  input  logic [DATA_W-1:0] dma_data_i,
  output logic              dma_ready_o,
  output logic              scsi_valid_o,
  output logic [DATA_W-1:0] scsi_data_o,
  input  logic              scsi_ready_i,
  output logic              latch_full_o,
  output logic              hold_full_o
);
  logic              latch_valid, latch_out_ready, hold_in_ready, hold_valid;
  logic [DATA_W-1:0] latch_data, hold_data;

  // latch drains to the hold register in sync mode, to the bus otherwise
  assign latch_out_ready = sync_i ? hold_in_ready : scsi_ready_i;

  scsi_stage_reg #(.DATA_W(DATA_W)) u_latch (
    .clk_i, .rst_ni, .flush_i,
    .in_valid_i (dma_valid_i),
    .in_data_i  (dma_data_i),
    .in_ready_o (dma_ready_o),
    .out_valid_o(latch_valid),
    .out_data_o (latch_data),
    .out_ready_i(latch_out_ready),
    .full_o     (latch_full_o)
  );

  scsi_stage_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .flush_i,
    .in_valid_i (sync_i && latch_valid),
    .in_data_i  (latch_data),
    .in_ready_o (hold_in_ready),
    .out_valid_o(hold_valid),
    .out_data_o (hold_data),
    .out_ready_i(scsi_ready_i),
    .full_o     (hold_full_o)
  );

  assign scsi_valid_o = sync_i ? hold_valid : latch_valid;
  assign scsi_data_o  = sync_i ? hold_data  : latch_data;

  p_hold_idle_async_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |-> !hold_full_o);
endmodule

// File: rtl/scsi_rx_stage.sv
`timescale 1ns/1ps
module scsi_rx_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              sync_i,
  input  logic              scsi_valid_i,
  input  logic [DATA_W-1:0] scsi_data_i,
  output logic              scsi_ready_o,
  output logic              dma_valid_o,
  output logic [DATA_W-1:0] dma_data_o,
  input  logic              dma_ready_i,
  output logic              latch_full_o
);
  logic              latch_in_ready, latch_valid;
  logic [DATA_W-1:0] latch_data;

  scsi_stage_reg #(.DATA_W(DATA_W)) u_latch (
    .clk_i, .rst_ni, .flush_i,
    .in_valid_i (!sync_i && scsi_valid_i),
    .in_data_i  (scsi_data_i),
    .in_ready_o (latch_in_ready),
    .out_valid_o(latch_valid),
    .out_data_o (latch_data),
    .out_ready_i(dma_ready_i),
    .full_o     (latch_full_o)
  );

  // sync data bypasses the latch
  assign scsi_ready_o = sync_i ? dma_ready_i  : latch_in_ready;
  assign dma_valid_o  = sync_i ? scsi_valid_i : latch_valid;
  assign dma_data_o   = sync_i ? scsi_data_i  : latch_data;

  p_latch_idle_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |-> !latch_full_o);
endmodule

// File: rtl/scsi_stage_path.sv
`timescale 1ns/1ps
module scsi_stage_path
  import scsi_stage_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              sync_mode_i,
  output logic              sync_active_o,
  input  logic              dma_tx_valid_i,
  input  logic [DATA_W-1:0] dma_tx_data_i,
  output logic              dma_tx_ready_o,
  output logic              scsi_tx_valid_o,
  output logic [DATA_W-1:0] scsi_tx_data_o,
  input  logic              scsi_tx_ready_i,
  input  logic              scsi_rx_valid_i,
  input  logic [DATA_W-1:0] scsi_rx_data_i,
  output logic              scsi_rx_ready_o,
  output logic              dma_rx_valid_o,
  output logic [DATA_W-1:0] dma_rx_data_o,
  input  logic              dma_rx_ready_i,
  output logic [STAT_W-1:0] status_o
);
  logic sync_q, all_empty, mode_idle;
  logic tx_latch_full, tx_hold_full, rx_latch_full;

  assign all_empty = !(tx_latch_full || tx_hold_full || rx_latch_full);
  assign mode_idle = all_empty && !dma_tx_valid_i && !scsi_rx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sync_q <= 1'b0;
    else if (mode_idle) sync_q <= sync_mode_i;
  end
  assign sync_active_o = sync_q;

  scsi_tx_stage #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .flush_i,
    .sync_i      (sync_q),
    .dma_valid_i (dma_tx_valid_i),
    .dma_data_i  (dma_tx_data_i),
    .dma_ready_o (dma_tx_ready_o),
    .scsi_valid_o(scsi_tx_valid_o),
    .scsi_data_o (scsi_tx_data_o),
    .scsi_ready_i(scsi_tx_ready_i),
    .latch_full_o(tx_latch_full),
    .hold_full_o (tx_hold_full)
  );

  scsi_rx_stage #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .flush_i,
    .sync_i      (sync_q),
    .scsi_valid_i(scsi_rx_valid_i),
    .scsi_data_i (scsi_rx_data_i),
    .scsi_ready_o(scsi_rx_ready_o),
    .dma_valid_o (dma_rx_valid_o),
    .dma_data_o  (dma_rx_data_o),
    .dma_ready_i (dma_rx_ready_i),
    .latch_full_o(rx_latch_full)
  );

  always_comb begin
    status_o               = '0;
    status_o[BIT_RX_LATCH] = rx_latch_full;
    status_o[BIT_TX_HOLD]  = tx_hold_full;
    status_o[BIT_TX_LATCH] = tx_latch_full;
  end

  p_mode_from_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_q) |-> $past(all_empty));

  p_flush_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> status_o[7:5] == 3'b000 && !scsi_tx_valid_o);
endmodule

// File: tb/scsi_stage_path_tb_top.sv
`timescale 1ns/1ps
module scsi_stage_path_tb_top;
  localparam int unsigned DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          flush_i = 1'b0, sync_mode_i = 1'b0;
  logic          sync_active_o;
  logic          dma_tx_valid_i = 1'b0, dma_tx_ready_o;
  logic [DW-1:0] dma_tx_data_i = '0;
  logic          scsi_tx_valid_o, scsi_tx_ready_i = 1'b0;
  logic [DW-1:0] scsi_tx_data_o;
  logic          scsi_rx_valid_i = 1'b0, scsi_rx_ready_o;
  logic [DW-1:0] scsi_rx_data_i = '0;
  logic          dma_rx_valid_o, dma_rx_ready_i = 1'b0;
  logic [DW-1:0] dma_rx_data_o;
  logic [7:0]    status_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  scsi_stage_path #(.DATA_W(DW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic quiet();
    dma_tx_valid_i = 0; scsi_tx_ready_i = 0; scsi_rx_valid_i = 0; dma_rx_ready_i = 0; flush_i = 0;
  endtask

  task automatic set_mode(input bit m);
    quiet();
    sync_mode_i = m;
    tick(); #1;
    chk(sync_active_o == m, "R9 mode taken when idle", sync_active_o, m);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] tx_q[$];
    logic [DW-1:0] rx_q[$];
    logic [DW-1:0] tx_next, rx_next;
    tx_next = 8'h01; rx_next = 8'h80;

    repeat (3) @(posedge clk_i);
    #1;
    chk(status_o == 8'h00, "R1 status", status_o, 0);
    chk(!scsi_tx_valid_o && !dma_rx_valid_o, "R1 valids", {scsi_tx_valid_o, dma_rx_valid_o}, 0);
    chk(sync_active_o == 0, "R1 mode", sync_active_o, 0);
    rst_ni = 1'b1;
    tick();

    // R2 async transmit latency
    dma_tx_valid_i = 1; dma_tx_data_i = 8'hA5; #1;
    chk(dma_tx_ready_o, "R7 empty latch ready", dma_tx_ready_o, 1);
    tick(); dma_tx_valid_i = 0; #1;
    chk(scsi_tx_valid_o && scsi_tx_data_o == 8'hA5, "R2 byte after one edge", scsi_tx_data_o, 8'hA5);
    chk(status_o == 8'h20, "R2 output latch flag", status_o, 8'h20);
    dma_tx_valid_i = 1; dma_tx_data_i = 8'h11; #1;
    chk(!dma_tx_ready_o, "R7 full latch refuses", dma_tx_ready_o, 0);
    dma_tx_valid_i = 0;
    // R6 one byte per cycle with both sides ready
    scsi_tx_ready_i = 1;
    for (int k = 1; k <= 3; k++) begin
      dma_tx_valid_i = 1; dma_tx_data_i = 8'(k); tick(); #1;
      chk(status_o == 8'h20 && scsi_tx_data_o == 8'(k), "R6 streaming flag", status_o, 8'h20);
    end
    dma_tx_valid_i = 0; tick(); #1;
    chk(status_o == 8'h00, "R6 flag clears on drain", status_o, 0);

    // R3 sync transmit through the hold register
    set_mode(1);
    dma_tx_valid_i = 1; dma_tx_data_i = 8'h3C; tick(); dma_tx_valid_i = 0; #1;
    chk(status_o == 8'h20 && !scsi_tx_valid_o, "R3 first edge in latch", status_o, 8'h20);
    tick(); #1;
    chk(status_o == 8'h40 && scsi_tx_valid_o && scsi_tx_data_o == 8'h3C, "R3 second edge in hold", status_o, 8'h40);
    dma_tx_valid_i = 1; dma_tx_data_i = 8'h5A; tick(); dma_tx_valid_i = 0; #1;
    chk(status_o == 8'h60, "R11 two bytes resident", status_o, 8'h60);
    chk(!dma_tx_ready_o, "R7 both stages full", dma_tx_ready_o, 0);
    chk(scsi_tx_data_o == 8'h3C, "R7 stalled byte unchanged", scsi_tx_data_o, 8'h3C);

    // R9 mode change ignored while bytes are resident
    sync_mode_i = 0; tick(); tick(); #1;
    chk(sync_active_o == 1, "R9 change ignored", sync_active_o, 1);
    chk(status_o == 8'h60, "R9 bytes untouched", status_o, 8'h60);

    // R8 flush
    flush_i = 1; tick(); flush_i = 0; #1;
    chk(status_o == 8'h00 && !scsi_tx_valid_o, "R8 flush empties", status_o, 0);
    tick(); #1;
    chk(sync_active_o == 0, "R9 change after flush", sync_active_o, 0);

    // R4 async receive
    scsi_rx_valid_i = 1; scsi_rx_data_i = 8'hC3; #1;
    chk(scsi_rx_ready_o, "R4 latch ready", scsi_rx_ready_o, 1);
    tick(); scsi_rx_valid_i = 0; #1;
    chk(status_o == 8'h80 && dma_rx_valid_o && dma_rx_data_o == 8'hC3, "R4 byte after one edge", status_o, 8'h80);
    dma_rx_ready_i = 1; tick(); dma_rx_ready_i = 0; #1;
    chk(status_o == 8'h00 && !dma_rx_valid_o, "R4 drained", status_o, 0);

    // R5 sync receive bypass
    set_mode(1);
    scsi_rx_valid_i = 1; scsi_rx_data_i = 8'h99; dma_rx_ready_i = 1; #1;
    chk(dma_rx_valid_o && dma_rx_data_o == 8'h99 && scsi_rx_ready_o, "R5 same-cycle bypass", dma_rx_data_o, 8'h99);
    tick(); #1;
    chk(status_o == 8'h00, "R5 input latch unused", status_o, 0);
    quiet();

    // sweep: both modes, every 4-cycle valid and ready pattern
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int vm = 0; vm < 16; vm++) begin
        for (int rm = 0; rm < 16; rm++) begin
          for (int c = 0; c < 28; c++) begin
            bit drain;
            int cap;
            drain = (c >= 22);
            cap = m ? 2 : 1;
            dma_tx_valid_i  = !drain && vm[c % 4];
            dma_tx_data_i   = tx_next;
            scsi_tx_ready_i = drain || rm[c % 4];
            scsi_rx_valid_i = !drain && rm[(c + 1) % 4];
            scsi_rx_data_i  = rx_next;
            dma_rx_ready_i  = drain || vm[(c + 2) % 4];
            #1;
            chk(status_o[4:0] == 0, "R10 low bits zero", status_o, status_o & 8'he0);
            chk($countones(status_o[7:5]) == tx_q.size() + rx_q.size(), "R11 flag count",
                $countones(status_o[7:5]), tx_q.size() + rx_q.size());
            if (m == 0) chk(!status_o[6], "R2 hold unused in async", status_o[6], 0);
            else begin
              chk(!status_o[7], "R5 input latch unused in sync", status_o[7], 0);
              chk(scsi_rx_ready_o == dma_rx_ready_i && dma_rx_valid_o == scsi_rx_valid_i,
                  "R5 bypass handshake", dma_rx_valid_o, scsi_rx_valid_i);
            end
            if (tx_q.size() == cap && !scsi_tx_ready_i)
              chk(!dma_tx_ready_o, "R7 tx refuse when full", dma_tx_ready_o, 0);
            if (tx_q.size() == 0)
              chk(dma_tx_ready_o, "R7 tx accept when empty", dma_tx_ready_o, 1);
            if (m == 0 && rx_q.size() == 1 && !dma_rx_ready_i)
              chk(!scsi_rx_ready_o, "R7 rx refuse when full", scsi_rx_ready_o, 0);
            if (dma_tx_valid_i && dma_tx_ready_o) begin tx_q.push_back(tx_next); tx_next++; end
            if (scsi_rx_valid_i && scsi_rx_ready_o) begin rx_q.push_back(rx_next); rx_next++; end
            if (scsi_tx_valid_o && scsi_tx_ready_i) begin
              chk(tx_q.size() > 0 && scsi_tx_data_o == tx_q[0], m ? "R3 order" : "R2 order",
                  scsi_tx_data_o, tx_q.size() > 0 ? tx_q[0] : 0);
              if (tx_q.size() > 0) void'(tx_q.pop_front());
            end
            if (dma_rx_valid_o && dma_rx_ready_i) begin
              chk(rx_q.size() > 0 && dma_rx_data_o == rx_q[0], m ? "R5 order" : "R4 order",
                  dma_rx_data_o, rx_q.size() > 0 ? rx_q[0] : 0);
              if (rx_q.size() > 0) void'(rx_q.pop_front());
            end
            tick();
          end
          #1;
          chk(status_o == 8'h00 && tx_q.size() == 0 && rx_q.size() == 0, "R6 fully drained",
              status_o, 0);
          tx_q.delete(); rx_q.delete();
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule